// File: doc/BRIEF.md
# Configuration Address Translator

This block turns a processor access that lands in a downstream configuration window into a type-0 configuration address for a PCI-style bus. It builds a 32-bit intermediate address. The low half comes from the access address and the high half comes from a software-held mapping value. From that address it decodes a one-hot device-select field, a function number and a register offset, then packs them with the current bus number into a configuration address that carries its enable bit.

Accesses are byte, halfword or word sized. Each one is dropped, rejected or forwarded to a downstream configuration responder with a request/acknowledge handshake. The block handles one request at a time. A forwarded access also produces a one-cycle pulse that clears the received-master-abort and received-target-abort bits held elsewhere in the bridge's status register. One bit of the mapping value turns the window off: reads then return all-ones and writes are discarded without reaching the bus.

Top module: `cfg_xlate_top`

## Requirements
- R1: The intermediate address is {map_reg[15:0], req_addr[15:0]}. The device, function and register fields of ds_addr are all taken from it.
- R2: When map_reg[16] is 1 and the access is aligned, nothing is forwarded and clr_abort stays low. One cycle after acceptance rsp_valid pulses, err stays low, and rsp_rdata is all-ones of the access width (0xFF, 0xFFFF or 0xFFFFFFFF), zero-extended.
- R3: The device-select field is intermediate bits [31:11]. ds_addr[15:11] is the index of its lowest set bit, even when several bits are set.
- R4: ds_addr[10:8] equals intermediate bits [10:8]. ds_addr[7:2] equals intermediate bits [7:2], and ds_addr[1:0] is always 0, whatever the access size.
- R5: ds_addr[23:16] is bus_num as sampled at acceptance, ds_addr[31] is 1, and ds_addr[30:24] is 0.
- R6: A type-0 access (map_reg[16] = 0) whose device-select field is all zeros is rejected. It is not forwarded.
- R7: Each forwarded access raises clr_abort for exactly one cycle, the first cycle of ds_valid. Rejected and dropped accesses do not raise it.
- R8: req_size encodes 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A halfword with req_addr[0] = 1, a word with req_addr[1:0] != 0, or a reserved size is rejected. This check is made before the map_reg[16] check.
- R9: After a forwarded access is accepted, req_ready stays low while ds_valid is high. ds_valid, ds_addr, ds_write, ds_size and ds_wdata hold steady until the cycle after ds_ack.
- R10: A forwarded access drives ds_write = req_write, ds_size = req_size and ds_wdata = req_wdata. Its response carries ds_rdata masked to the access width.
- R11: The response to a forwarded access is a one-cycle rsp_valid in the cycle after ds_ack is sampled. In that same cycle ds_valid is low and req_ready is high.
- R12: A rejected access gives, one cycle after acceptance, rsp_valid and err together for one cycle with rsp_rdata = 0. After reset, req_ready is 1 and ds_valid, rsp_valid, err and clr_abort are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 32 | Access address inside the window |
| req_wdata | input | 32 | Write data |
| map_reg | input | 32 | Mapping value: [15:0] upper address half, [16] window off |
| bus_num | input | 8 | Current bus number |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data, zero-extended |
| err | output | 1 | Rejected access, pulses with rsp_valid |
| clr_abort | output | 1 | Pulse clearing both received-abort status bits |
| ds_valid | output | 1 | Downstream configuration request |
| ds_write | output | 1 | Downstream write |
| ds_size | output | 2 | Downstream access size |
| ds_addr | output | 32 | Configuration address with enable bit |
| ds_wdata | output | 32 | Downstream write data |
| ds_ack | input | 1 | Downstream completion |
| ds_rdata | input | 32 | Downstream read data |

## Verification
The hardest case to reach is a forwarded access that sits waiting for an acknowledge that comes late. During that wait, ready, the held command and the one-shot clear pulse must all behave correctly across several idle cycles. The bench gets there by playing the downstream responder inside each access task and holding ds_ack back for a chosen number of cycles. It checks every waiting cycle. The orderings between checks are also driven on purpose: a misaligned access with the window off, and a device-select field with several bits set.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int ADDR_W     = 32;
  localparam int HALF_W     = 16;
  localparam int OFF_BIT    = 16;
  localparam int SEL_LSB    = 11;
  localparam int SEL_W      = ADDR_W - SEL_LSB;
  localparam int DEV_W      = 5;
  localparam int FN_LSB     = 8;
  localparam int FN_W       = 3;
  localparam int REG_LSB    = 2;
  localparam int REG_W      = FN_LSB - REG_LSB;
  localparam int BUS_W      = 8;
  localparam int PAD_W      = ADDR_W - 1 - BUS_W - DEV_W - FN_W - REG_W - REG_LSB;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic              misalign;
    logic              window_off;
    logic              sel_zero;
    logic [ADDR_W-1:0] cfg_addr;
  } decode_t;

  function automatic logic [ADDR_W-1:0] width_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: width_mask = ADDR_W'(32'h0000_00FF);
      SZ_HALF: width_mask = ADDR_W'(32'h0000_FFFF);
      default: width_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/cfg_tz_index.sv
module cfg_tz_index #(
  parameter int W     = 21,
  parameter int IDX_W = 5
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             none
);
  always_comb begin
    idx  = '0;
    none = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx  = IDX_W'(i);
        none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_xlate_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] map,
  input  logic [BUS_W-1:0]  bus,
  output decode_t           dec
);
  logic [ADDR_W-1:0] inter;
  logic [SEL_W-1:0]  sel;
  logic [DEV_W-1:0]  dev;
  logic              none;
  logic              unused_bits;

  assign inter = {map[HALF_W-1:0], addr[HALF_W-1:0]};
  assign sel   = inter[ADDR_W-1:SEL_LSB];
  assign unused_bits = ^{map[ADDR_W-1:OFF_BIT+1], addr[ADDR_W-1:HALF_W]};

  cfg_tz_index #(.W(SEL_W), .IDX_W(DEV_W)) u_tz (
    .vec  (sel),
    .idx  (dev),
    .none (none)
  );

  always_comb begin
    dec.misalign   = 1'b0;
    case (size)
      SZ_BYTE: dec.misalign = 1'b0;
      SZ_HALF: dec.misalign = addr[0];
      SZ_WORD: dec.misalign = |addr[1:0];
      default: dec.misalign = 1'b1;
    endcase
    dec.window_off = map[OFF_BIT];
    dec.sel_zero   = none;
    dec.cfg_addr   = {1'b1, {PAD_W{1'b0}}, bus, dev,
                      inter[FN_LSB+FN_W-1:FN_LSB],
                      inter[FN_LSB-1:REG_LSB], {REG_LSB{1'b0}}};
  end
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_wdata,
  input  decode_t           dec,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_rdata,
  output logic              err,
  output logic              clr_abort,
  output logic              ds_valid,
  output logic              ds_write,
  output logic [1:0]        ds_size,
  output logic [ADDR_W-1:0] ds_addr,
  output logic [ADDR_W-1:0] ds_wdata,
  input  logic              ds_ack,
  input  logic [ADDR_W-1:0] ds_rdata
);
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} state_e;

  state_e            state_q, state_d;
  logic              write_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q, wdata_q;
  logic              clr_q, clr_d;
  logic              rsp_v_q, rsp_v_d;
  logic              err_q, err_d;
  logic [ADDR_W-1:0] rdata_q, rdata_d;
  logic              accept, load_cmd;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    load_cmd = 1'b0;
    clr_d    = 1'b0;
    rsp_v_d  = 1'b0;
    err_d    = 1'b0;
    rdata_d  = rdata_q;
    if (accept) begin
      if (dec.misalign || (!dec.window_off && dec.sel_zero)) begin
        rsp_v_d = 1'b1;
        err_d   = 1'b1;
        rdata_d = '0;
      end else if (dec.window_off) begin
        rsp_v_d = 1'b1;
        rdata_d = width_mask(req_size);
      end else begin
        state_d  = ST_WAIT;
        load_cmd = 1'b1;
        clr_d    = 1'b1;
      end
    end
    if ((state_q == ST_WAIT) && ds_ack) begin
      state_d = ST_IDLE;
      rsp_v_d = 1'b1;
      rdata_d = ds_rdata & width_mask(size_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      clr_q   <= 1'b0;
      rsp_v_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      clr_q   <= clr_d;
      rsp_v_q <= rsp_v_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_cmd) begin
      write_q <= req_write;
      size_q  <= req_size;
      addr_q  <= dec.cfg_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rsp_v_d) begin
      rdata_q <= rdata_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign ds_valid  = (state_q == ST_WAIT);
  assign ds_write  = write_q;
  assign ds_size   = size_q;
  assign ds_addr   = addr_q;
  assign ds_wdata  = wdata_q;
  assign clr_abort = clr_q;
  assign rsp_valid = rsp_v_q;
  assign err       = err_q;
  assign rsp_rdata = rdata_q;

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid |-> !req_ready);
  assert_cmd_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_ack) |=> (ds_valid && $stable(ds_addr) && $stable(ds_wdata)));
  assert_clear_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_abort |=> !clr_abort);
  assert_clear_with_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_abort |-> ds_valid);
  assert_reject_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rsp_valid && (rsp_rdata == '0) && !ds_valid));
  assert_ack_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && ds_ack) |=> (rsp_valid && !ds_valid && req_ready));
  assert_enable_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid |-> (ds_addr[ADDR_W-1] && (ds_addr[1:0] == 2'b00)));
endmodule

// File: rtl/cfg_xlate_top.sv
module cfg_xlate_top
  import cfg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [31:0] map_reg,
  input  logic [7:0]  bus_num,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        err,
  output logic        clr_abort,
  output logic        ds_valid,
  output logic        ds_write,
  output logic [1:0]  ds_size,
  output logic [31:0] ds_addr,
  output logic [31:0] ds_wdata,
  input  logic        ds_ack,
  input  logic [31:0] ds_rdata
);
  decode_t dec;

  cfg_decode u_decode (
    .addr (req_addr),
    .size (req_size),
    .map  (map_reg),
    .bus  (bus_num),
    .dec  (dec)
  );

  cfg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .dec       (dec),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .err       (err),
    .clr_abort (clr_abort),
    .ds_valid  (ds_valid),
    .ds_write  (ds_write),
    .ds_size   (ds_size),
    .ds_addr   (ds_addr),
    .ds_wdata  (ds_wdata),
    .ds_ack    (ds_ack),
    .ds_rdata  (ds_rdata)
  );
endmodule

// File: tb/cfg_xlate_top_tb.sv
module cfg_xlate_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_ready;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata, map_reg;
  logic [7:0]  bus_num;
  logic        rsp_valid, err, clr_abort;
  logic [31:0] rsp_rdata;
  logic        ds_valid, ds_write, ds_ack;
  logic [1:0]  ds_size;
  logic [31:0] ds_addr, ds_wdata, ds_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_xlate_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .map_reg(map_reg), .bus_num(bus_num),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err(err),
    .clr_abort(clr_abort), .ds_valid(ds_valid), .ds_write(ds_write),
    .ds_size(ds_size), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
    .ds_ack(ds_ack), .ds_rdata(ds_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  // One access; the task plays the downstream responder with lat wait cycles.
  task automatic run(input string tag, input logic [1:0] sz, input logic wr,
                     input logic [31:0] a, input logic [31:0] wd,
                     input logic [31:0] mp, input logic [7:0] bs,
                     input logic [31:0] stub_rd, input int lat);
    logic [31:0] inter, exp_addr;
    logic [20:0] sel;
    logic [4:0]  dev;
    bit mis, off, zero;
    mis = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00);
    off = mp[16];
    inter = {mp[15:0], a[15:0]};
    sel = inter[31:11];
    zero = (sel == '0);
    dev = '0;
    for (int i = 20; i >= 0; i--) if (sel[i]) dev = 5'(i);
    exp_addr = {1'b1, 7'b0, bs, dev, inter[10:8], inter[7:2], 2'b00};

    @(negedge clk);
    req_valid = 1'b1; req_size = sz; req_write = wr; req_addr = a;
    req_wdata = wd; map_reg = mp; bus_num = bs;
    @(negedge clk);
    req_valid = 1'b0;
    if (mis || (!off && zero)) begin
      check(err && rsp_valid && rsp_rdata == 0, mis ? "R8 reject" : "R6 reject",
            {30'b0, err, rsp_valid}, 32'h3);
      check(!ds_valid && !clr_abort, "R12 no forward", {30'b0, ds_valid, clr_abort}, 0);
    end else if (off) begin
      check(rsp_valid && !err && rsp_rdata == mask_of(sz), "R2 window off",
            rsp_rdata, mask_of(sz));
      check(!ds_valid && !clr_abort, "R2 dropped", {30'b0, ds_valid, clr_abort}, 0);
    end else begin
      check(ds_valid && ds_addr == exp_addr, tag, ds_addr, exp_addr);
      check(ds_write == wr && ds_size == sz && ds_wdata == wd, "R10 forward",
            ds_wdata, wd);
      check(clr_abort && !req_ready, "R7 clear pulse", {30'b0, clr_abort, req_ready}, 32'h2);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        check(ds_valid && !req_ready && !clr_abort && ds_addr == exp_addr && !rsp_valid,
              "R9 hold", ds_addr, exp_addr);
      end
      ds_ack = 1'b1; ds_rdata = stub_rd;
      @(negedge clk);
      ds_ack = 1'b0;
      check(rsp_valid && !err && rsp_rdata == (stub_rd & mask_of(sz)), "R10 read data",
            rsp_rdata, stub_rd & mask_of(sz));
      check(!ds_valid && req_ready, "R11 release", {30'b0, ds_valid, req_ready}, 32'h1);
    end
    @(negedge clk);
    check(!rsp_valid && !err && !clr_abort, "R11 single pulse",
          {29'b0, rsp_valid, err, clr_abort}, 0);
  endtask

  task automatic t_reset();
    check(req_ready && !ds_valid && !rsp_valid && !err && !clr_abort, "R12 reset",
          {27'b0, req_ready, ds_valid, rsp_valid, err, clr_abort}, 32'h10);
  endtask

  task automatic t_forward_reads();
    run("R4 byte read fields", 2'd0, 1'b0, 32'h0000_0315, 0, 32'h0000_0002, 8'h00, 32'hA1B2C3D4, 0);
    run("R1 upper half from map", 2'd2, 1'b0, 32'hFFFF_0000, 0, 32'h0000_8000, 8'h3C, 32'h12345678, 1);
    run("R3 lowest of many", 2'd1, 1'b0, 32'h0000_F8A2, 0, 32'h0000_0003, 8'h7E, 32'hDEADBEEF, 0);
    run("R5 bus packing", 2'd2, 1'b0, 32'h0000_8004, 0, 32'h0000_0000, 8'hFF, 32'h0BADF00D, 2);
  endtask

  task automatic t_writes();
    run("R10 word write", 2'd2, 1'b1, 32'h0000_4708, 32'hCAFE_0001, 32'h0000_0010, 8'h05, 32'h0, 1);
    run("R4 halfword write", 2'd1, 1'b1, 32'h0000_1236, 32'h0000_5A5A, 32'h0000_0000, 8'h01, 32'h0, 0);
  endtask

  task automatic t_window_off();
    run("R2 byte", 2'd0, 1'b0, 32'h0000_0801, 0, 32'h0001_0000, 8'h02, 0, 0);
    run("R2 half", 2'd1, 1'b0, 32'h0000_0802, 0, 32'h0001_FFFF, 8'h02, 0, 0);
    run("R2 word write", 2'd2, 1'b1, 32'h0000_0000, 32'h1111_2222, 32'h0001_0000, 8'h02, 0, 0);
  endtask

  task automatic t_sel_zero();
    run("R6 empty select", 2'd2, 1'b0, 32'h0000_07FC, 0, 32'h0000_0000, 8'h09, 0, 0);
  endtask

  task automatic t_align();
    run("R8 half odd", 2'd1, 1'b0, 32'h0000_0803, 0, 32'h0000_0000, 8'h00, 0, 0);
    run("R8 word off", 2'd2, 1'b1, 32'h0000_0802, 32'h1, 32'h0000_0000, 8'h00, 0, 0);
    run("R8 reserved size", 2'd3, 1'b0, 32'h0000_0800, 0, 32'h0000_0000, 8'h00, 0, 0);
    run("R8 before window off", 2'd2, 1'b0, 32'h0000_0801, 0, 32'h0001_0000, 8'h00, 0, 0);
  endtask

  task automatic t_backpressure();
    run("R9 long wait", 2'd2, 1'b0, 32'h0000_2040, 0, 32'h0000_0000, 8'h44, 32'h8765_4321, 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; map_reg = '0; bus_num = '0;
    ds_ack = 1'b0; ds_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward_reads();
    t_writes();
    t_window_off();
    t_sel_zero();
    t_align();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule